// File: doc/BRIEF.md
# Programmable Transmit Threshold Interrupt

This block produces two flags for a UART transmit path. The first is the transmit interrupt condition, which goes to a separate priority unit. The second is the transmitter status bit that software polls. Its inputs are the fill level of a transmit FIFO and a few control bits. Two behaviours are selectable:

- **Legacy behaviour.** The interrupt condition and the status bit both indicate an empty transmitter.
- **Threshold behaviour.** The interrupt condition is raised whenever the FIFO holds no more than a programmable number of characters, so software can top up the FIFO before it drains. The status bit then reports a full FIFO instead, so software can keep writing characters until the bit sets.

The threshold behaviour needs two bits to be set: the FIFO enable bit and the threshold-mode enable bit. If the FIFO enable bit is clear, the block falls back to the legacy behaviour whatever the mode bit says. The FIFO storage, the serializer and the priority encoding of interrupts all lie outside this block. Both outputs are registered and follow their inputs with one clock of latency.

Top module: `txthr_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tx_irq_cond` becomes 0 and `tx_stat` becomes 1. After reset is released, these values hold until the first edge at which the inputs are sampled.
- R2: The threshold behaviour is active only when `fifo_en` is 1 and `thr_mode_en` is 1. When `fifo_en` is 0, the legacy behaviour applies regardless of `thr_mode_en`.
- R3: The `thr_sel` codes select the threshold as follows: 2'b00 selects 0 entries, 2'b01 selects 2 entries, 2'b10 selects DEPTH/4 entries and 2'b11 selects DEPTH/2 entries. With DEPTH = 16, these are 0, 2, 4 and 8.
- R4: With the threshold behaviour active, `tx_irq_cond` is 1 when `tx_level` is less than or equal to the selected threshold. It is 0 as soon as `tx_level` exceeds that threshold.
- R5: With the threshold behaviour active, `tx_stat` is 1 exactly when `tx_level` equals DEPTH (the FIFO is full).
- R6: With the threshold behaviour inactive, `tx_irq_cond` and `tx_stat` are both 1 exactly when `tx_level` is 0.
- R7: With the threshold behaviour inactive, `thr_sel` has no effect on either output.
- R8: Each output reflects the inputs sampled at the previous rising clock edge. A change on an input does not appear on the outputs before the next rising edge.
- R9: `tx_level` ranges from 0 to DEPTH. A value above DEPTH is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_level | input | $clog2(DEPTH+1) | Number of characters in the transmit FIFO |
| fifo_en | input | 1 | FIFO enable. When 0, the threshold behaviour is forced off |
| thr_sel | input | 2 | Threshold select code |
| thr_mode_en | input | 1 | Threshold behaviour enable |
| tx_irq_cond | output | 1 | Registered transmit interrupt condition |
| tx_stat | output | 1 | Registered transmitter status bit: empty in legacy behaviour, full in threshold behaviour |

## Verification
The bench uses the default DEPTH = 16, which makes the level port 5 bits wide. This small configuration allows an exhaustive sweep over every combination of the FIFO enable bit, the mode bit, the four select codes and all 17 fill levels. The sweep reaches every threshold boundary, the level just above each threshold, and the full level. Because each new input set is checked just before the next clock edge, the same sweep also confirms the one-cycle latency.

// File: rtl/txthr_pkg.sv
// Package: txthr_pkg
// Shared types for the transmit-threshold interrupt block.
// Assumes nothing beyond the types declared here.
package txthr_pkg;

    // Threshold select codes. The code values are fixed because software writes them.
    typedef enum logic [1:0] {
        THR_EMPTY   = 2'b00,
        THR_TWO     = 2'b01,
        THR_QUARTER = 2'b10,
        THR_HALF    = 2'b11
    } thr_sel_e;

    // The pair of flags that the block publishes.
    typedef struct packed {
        logic irq;
        logic stat;
    } tx_flags_t;

endpackage

// File: rtl/txthr_thresh_dec.sv
// Module: txthr_thresh_dec
// Turns the two-bit select code into a fill-level threshold.
// Assumes DEPTH >= 8, so that the quarter and half thresholds are nonzero and ordered.
module txthr_thresh_dec
    import txthr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       sel,
    output logic [LVL_W-1:0] thr
);

    localparam logic [LVL_W-1:0] QUARTER = LVL_W'(DEPTH / 4);
    localparam logic [LVL_W-1:0] HALF    = LVL_W'(DEPTH / 2);

    thr_sel_e sel_e;
    assign sel_e = thr_sel_e'(sel);

    // Map each select code to its entry count.
    always_comb begin
        unique case (sel_e)
            THR_EMPTY:   thr = '0;
            THR_TWO:     thr = LVL_W'(2);
            THR_QUARTER: thr = QUARTER;
            THR_HALF:    thr = HALF;
            default:     thr = '0;
        endcase
    end

    // R3: the decoded threshold never exceeds half the FIFO.
    always_comb begin
        AST_THR_BOUND: assert (thr <= HALF); // R3
    end

endmodule

// File: rtl/txthr_eval.sv
// Module: txthr_eval
// Combinational evaluation of the next interrupt and status flags.
// Assumes level is at most DEPTH and thr is a decoded threshold.
module txthr_eval
    import txthr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr,
    input  logic             fifo_en,
    input  logic             mode_en,
    output logic             mode_act,
    output tx_flags_t        nxt
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic is_empty;
    logic is_full;
    logic at_or_below;

    // Threshold behaviour needs both enables; disabled FIFOs override the mode bit.
    assign mode_act = fifo_en & mode_en;

    // Level comparisons shared by both behaviours.
    always_comb begin
        is_empty    = (level == '0);
        is_full     = (level == FULL);
        at_or_below = (level <= thr);
    end

    // Pick flag meanings according to the active behaviour.
    always_comb begin
        if (mode_act) begin
            nxt.irq  = at_or_below;
            nxt.stat = is_full;
        end else begin
            nxt.irq  = is_empty;
            nxt.stat = is_empty;
        end
    end

endmodule

// File: rtl/txthr_out_reg.sv
// Module: txthr_out_reg
// Output register stage for the flag pair. Reset reports an empty transmitter with no interrupt.
// Assumes a synchronous, active-low reset.
module txthr_out_reg
    import txthr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tx_flags_t d,
    output tx_flags_t q
);

    // Capture the next flags on every rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.irq  <= 1'b0;
            q.stat <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/txthr_irq.sv
// Module: txthr_irq
// Top of the transmit-threshold interrupt block. It produces the registered transmit
// interrupt condition and the transmitter status bit from the FIFO level and control bits.
// Assumes a DEPTH-entry FIFO (DEPTH >= 8) whose level never exceeds DEPTH.
module txthr_irq
    import txthr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             fifo_en,
    input  logic [1:0]       thr_sel,
    input  logic             thr_mode_en,
    output logic             tx_irq_cond,
    output logic             tx_stat
);

    logic [LVL_W-1:0] thr;
    logic             mode_act;
    tx_flags_t        nxt;
    tx_flags_t        q;

    txthr_thresh_dec #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dec (
        .sel (thr_sel),
        .thr (thr)
    );

    txthr_eval #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_eval (
        .level    (tx_level),
        .thr      (thr),
        .fifo_en  (fifo_en),
        .mode_en  (thr_mode_en),
        .mode_act (mode_act),
        .nxt      (nxt)
    );

    txthr_out_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (q)
    );

    assign tx_irq_cond = q.irq;
    assign tx_stat     = q.stat;

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH)); // R9
    AST_FIFO_OFF_NO_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_level != '0) |=> !tx_irq_cond); // R2
    AST_ABOVE_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act && tx_level > thr) |=> !tx_irq_cond); // R4
    AST_FULL_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act && tx_level == LVL_W'(DEPTH)) |=> tx_stat); // R5
    AST_LEGACY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_act && tx_level == '0) |=> (tx_irq_cond && tx_stat)); // R6

endmodule

// File: tb/txthr_irq_tb.sv
`timescale 1ns/1ps
module txthr_irq_tb;

    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level = '0;
    logic             fifo_en = 1'b0;
    logic [1:0]       thr_sel = 2'b00;
    logic             thr_mode_en = 1'b0;
    logic             tx_irq_cond;
    logic             tx_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    txthr_irq #(.DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_level    (tx_level),
        .fifo_en     (fifo_en),
        .thr_sel     (thr_sel),
        .thr_mode_en (thr_mode_en),
        .tx_irq_cond (tx_irq_cond),
        .tx_stat     (tx_stat)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (fe=%b me=%b sel=%0d lvl=%0d)",
                     req, act, exp, fifo_en, thr_mode_en, thr_sel, tx_level);
        end
    endtask

    function automatic int thr_of(input int s);
        case (s)
            0: return 0;
            1: return 2;
            2: return DEPTH / 4;
            default: return DEPTH / 2;
        endcase
    endfunction

    initial begin
        logic prev_irq, prev_stat;
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1 irq", tx_irq_cond, 1'b0);
        check("R1 stat", tx_stat, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        tx_level = 5'd3;
        #1;
        check("R1 hold irq", tx_irq_cond, 1'b0);
        check("R1 hold stat", tx_stat, 1'b1);
        @(negedge clk);
        prev_irq  = tx_irq_cond;
        prev_stat = tx_stat;
        for (int fe = 0; fe < 2; fe++) begin
            for (int me = 0; me < 2; me++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int l = 0; l <= DEPTH; l++) begin
                        bit act;
                        logic e_irq, e_stat;
                        fifo_en = fe[0];
                        thr_mode_en = me[0];
                        thr_sel = s[1:0];
                        tx_level = LVL_W'(l);
                        // R8: outputs unchanged before the next edge
                        #1;
                        check("R8 irq", tx_irq_cond, prev_irq);
                        check("R8 stat", tx_stat, prev_stat);
                        @(negedge clk);
                        act = (fe == 1) && (me == 1);
                        if (act) begin
                            e_irq  = (l <= thr_of(s)); // R3 threshold map
                            e_stat = (l == DEPTH);
                            check("R3/R4 irq", tx_irq_cond, e_irq);
                            check("R5 stat", tx_stat, e_stat);
                        end else begin
                            e_irq  = (l == 0);
                            e_stat = (l == 0);
                            if (me == 1) begin
                                // R2: mode bit set but FIFOs off
                                check("R2 irq", tx_irq_cond, e_irq);
                                check("R2 stat", tx_stat, e_stat);
                            end else if (s != 0) begin
                                // R7: select ignored while inactive
                                check("R7 irq", tx_irq_cond, e_irq);
                                check("R7 stat", tx_stat, e_stat);
                            end else begin
                                check("R6 irq", tx_irq_cond, e_irq);
                                check("R6 stat", tx_stat, e_stat);
                            end
                        end
                        prev_irq  = e_irq;
                        prev_stat = e_stat;
                    end
                end
            end
        end
        // R9: the sweep above kept the level within 0..DEPTH
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule